// File: doc/BRIEF.md
# Transmit Queue to Priority Channel Scheduler

This block holds the state of a set of transmit queues, each a ring described by an 8-bit read index and an 8-bit write index, and decides which queue is served next. Each queue is bound to one output channel by a programmable channel number. Several queues may share one channel. Whenever the downstream DMA engine asks for work by raising `take`, the block picks one eligible queue and issues a registered grant. The grant carries the queue number, its channel and the ring index to fetch. In the same cycle the block advances that queue's read index.

Software programs the block through a single write port. Each queue has a status word with embedded per-bit write enables, so one write can change some fields and leave the others alone. The empty flags of all queues sit in one register, which uses the same kind of enable mask. A channel-enable byte stops whole channels from requesting. An interrupt mask picks which queues pulse their interrupt line when their read index advances.

Address map: bits 5:4 of `cfg_addr` select the region and bits 3:0 select the queue or register. Region 0 holds the queue status words, region 1 the write indices and region 2 the read indices. Region 3 holds miscellaneous registers: select 0 is the empty-flag register, select 1 the channel enable and select 2 the interrupt mask.

Top module: `qsched_top`

## Requirements
- R1: After reset no grant is issued, every queue reads as empty, and all channels, queues and interrupts are disabled. A queue that is activated but whose write index has never been written is not granted.
- R2: A status write changes a field only where its enable bit is set in the same write. The enable for bit n is bit n+10. The fields are: bit 0 = active, bits 3:1 = channel number, bit 5 = window-space-left, bit 8 = acknowledged-window mode.
- R3: A queue is eligible when all of these hold: it is active, its empty flag is clear, and its channel is enabled. A queue in acknowledged-window mode must also have window-space-left set.
- R4: When eligible queues sit on different channels, the channel with the highest number wins.
- R5: Among eligible queues on the winning channel, the winner is the first queue after the one last granted on that channel, in rising queue order with wrap-around. The first grant on a channel after reset starts the search at queue 0.
- R6: When `take` is high and some queue is eligible, the grant outputs are valid in the next cycle. `gnt_idx` then equals the read index before the advance, the read index increments by one, and `rd_adv` has a single bit set, the bit of the granted queue.
- R7: Writing a read or write index, or advancing a read index, sets that queue's empty flag to (read index == write index). A queue with N entries therefore yields exactly N grants.
- R8: An empty-register write updates the flag of queue q to bit q only where bit q+16 is set. A forced empty flag blocks grants, and clearing it lets them resume.
- R9: The channel-enable register holds bit c for channel c. Queues on a disabled channel are never granted.
- R10: In the grant cycle, `irq` bit q pulses when queue q advances and interrupt-mask bit q is set.
- R11: Ring indices wrap from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Region (5:4) and queue or register select (3:0) |
| cfg_data | input | 32 | Configuration write data |
| take | input | 1 | Downstream request for the next grant |
| gnt_vld | output | 1 | Grant valid, registered |
| gnt_queue | output | 4 | Granted queue number |
| gnt_chan | output | 3 | Channel of the granted queue |
| gnt_idx | output | 8 | Ring index to fetch |
| rd_adv | output | 16 | Per-queue read index advance pulse |
| irq | output | 16 | Per-queue interrupt pulse |

## Verification
A behavioural model in the bench predicts every output in every cycle. The stimulus covers several distinct patterns:
- A single queue drains until its indices meet, which shows whether the emptiness update lands in the right cycle.
- Queues on three different channels compete, which tells strict channel priority apart from plain queue order.
- Three queues share one channel, which separates true round-robin from lowest-number-first.
- Partial status writes, forced empty flags, disabled channels and a window-limited queue in acknowledged mode each show whether gating happens at the right field.
- A ring starting at index 254 exposes faulty index wrap.

// File: rtl/qsched_pkg.sv
package qsched_pkg;
  // Status word field positions; enables sit ST_WE_OFS above the field bit.
  localparam int unsigned ST_ACT     = 0;
  localparam int unsigned ST_CH_LSB  = 1;
  localparam int unsigned ST_WSL     = 5;
  localparam int unsigned ST_ACK     = 8;
  localparam int unsigned ST_WE_OFS  = 10;
  // Empty-register enable offset
  localparam int unsigned EMP_WE_OFS = 16;

  typedef enum logic [1:0] {
    RG_STAT = 2'd0,
    RG_WPTR = 2'd1,
    RG_RPTR = 2'd2,
    RG_MISC = 2'd3
  } region_e;

  localparam int unsigned MISC_EMPTY = 0;
  localparam int unsigned MISC_CHEN  = 1;
  localparam int unsigned MISC_IRQM  = 2;
endpackage

// File: rtl/qsched_regs.sv
module qsched_regs
  import qsched_pkg::*;
#(
  parameter int unsigned NQ  = 16,
  parameter int unsigned NCH = 8,
  parameter int unsigned IW  = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfg_we,
  input  logic [$clog2(NQ)+1:0]        cfg_addr,
  input  logic [31:0]                  cfg_data,
  input  logic                         adv_en,
  input  logic [$clog2(NQ)-1:0]        adv_q,
  output logic [NQ-1:0]                q_act,
  output logic [NQ-1:0]                q_wsl,
  output logic [NQ-1:0]                q_ack,
  output logic [NQ-1:0]                q_empty,
  output logic [NQ-1:0][$clog2(NCH)-1:0] q_ch,
  output logic [NQ-1:0][IW-1:0]        q_rd,
  output logic [NCH-1:0]               chen,
  output logic [NQ-1:0]                irqm
);
  localparam int unsigned QW = $clog2(NQ);
  localparam int unsigned CW = $clog2(NCH);

  region_e          reg_sel;
  logic [QW-1:0]    reg_idx;
  logic             misc_we;

  assign reg_sel = region_e'(cfg_addr[QW+1:QW]);
  assign reg_idx = cfg_addr[QW-1:0];
  assign misc_we = cfg_we && (reg_sel == RG_MISC);

  for (genvar gi = 0; gi < NQ; gi++) begin : g_q
    logic          a_r, w_r, k_r, e_r;
    logic [CW-1:0] c_r;
    logic [IW-1:0] rp_r, wp_r, rp_nx;
    logic          hit;

    assign hit   = cfg_we && (reg_idx == QW'(gi));
    assign rp_nx = rp_r + 1'b1;

    always_ff @(posedge clk) begin
      if (rst) begin
        a_r  <= 1'b0;
        w_r  <= 1'b0;
        k_r  <= 1'b0;
        e_r  <= 1'b1;
        c_r  <= '0;
        rp_r <= '0;
        wp_r <= '0;
      end else begin
        if (hit && reg_sel == RG_STAT) begin
          if (cfg_data[ST_WE_OFS+ST_ACT]) a_r <= cfg_data[ST_ACT];
          if (cfg_data[ST_WE_OFS+ST_WSL]) w_r <= cfg_data[ST_WSL];
          if (cfg_data[ST_WE_OFS+ST_ACK]) k_r <= cfg_data[ST_ACK];
          for (int b = 0; b < CW; b++) begin
            if (cfg_data[ST_WE_OFS+ST_CH_LSB+b]) c_r[b] <= cfg_data[ST_CH_LSB+b];
          end
        end
        if (hit && reg_sel == RG_WPTR) begin
          wp_r <= cfg_data[IW-1:0];
          e_r  <= (cfg_data[IW-1:0] == rp_r);
        end else if (hit && reg_sel == RG_RPTR) begin
          rp_r <= cfg_data[IW-1:0];
          e_r  <= (cfg_data[IW-1:0] == wp_r);
        end else if (adv_en && adv_q == QW'(gi)) begin
          rp_r <= rp_nx;
          e_r  <= (rp_nx == wp_r);
        end
        if (misc_we && reg_idx == QW'(MISC_EMPTY) && cfg_data[EMP_WE_OFS+gi])
          e_r <= cfg_data[gi];
      end
    end

    assign q_act[gi]   = a_r;
    assign q_wsl[gi]   = w_r;
    assign q_ack[gi]   = k_r;
    assign q_empty[gi] = e_r;
    assign q_ch[gi]    = c_r;
    assign q_rd[gi]    = rp_r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chen <= '0;
      irqm <= '0;
    end else if (misc_we) begin
      if (reg_idx == QW'(MISC_CHEN)) chen <= cfg_data[NCH-1:0];
      if (reg_idx == QW'(MISC_IRQM)) irqm <= cfg_data[NQ-1:0];
    end
  end
endmodule

// File: rtl/qsched_pick.sv
module qsched_pick #(
  parameter int unsigned NQ  = 16,
  parameter int unsigned NCH = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           take,
  input  logic [NQ-1:0]                  q_act,
  input  logic [NQ-1:0]                  q_wsl,
  input  logic [NQ-1:0]                  q_ack,
  input  logic [NQ-1:0]                  q_empty,
  input  logic [NQ-1:0][$clog2(NCH)-1:0] q_ch,
  input  logic [NCH-1:0]                 chen,
  output logic                           hit,
  output logic [$clog2(NQ)-1:0]          sel_q,
  output logic [$clog2(NCH)-1:0]         sel_ch
);
  localparam int unsigned QW = $clog2(NQ);
  localparam int unsigned CW = $clog2(NCH);

  logic [NQ-1:0]          elig;
  logic [NCH-1:0]         ch_has;
  logic [NCH-1:0][QW-1:0] rr_last;
  logic [QW-1:0]          last, cand;

  always_comb begin
    for (int q = 0; q < NQ; q++)
      elig[q] = q_act[q] && !q_empty[q] && chen[q_ch[q]] && (!q_ack[q] || q_wsl[q]);
    ch_has = '0;
    for (int q = 0; q < NQ; q++)
      if (elig[q]) ch_has[q_ch[q]] = 1'b1;
  end

  // Highest-numbered channel with work wins
  always_comb begin
    sel_ch = '0;
    for (int c = 0; c < NCH; c++)
      if (ch_has[c]) sel_ch = CW'(c);
  end

  // Round-robin inside the winning channel, starting after the last grant
  always_comb begin
    last  = rr_last[sel_ch];
    sel_q = '0;
    cand  = '0;
    for (int k = NQ; k >= 1; k--) begin
      cand = last + QW'(k);
      if (elig[cand] && q_ch[cand] == sel_ch) sel_q = cand;
    end
  end

  assign hit = |ch_has;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) rr_last[c] <= QW'(NQ - 1);
    end else if (take && hit) begin
      rr_last[sel_ch] <= sel_q;
    end
  end
endmodule

// File: rtl/qsched_top.sv
module qsched_top #(
  parameter int unsigned NQ  = 16,
  parameter int unsigned NCH = 8,
  parameter int unsigned IW  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [$clog2(NQ)+1:0]   cfg_addr,
  input  logic [31:0]             cfg_data,
  input  logic                    take,
  output logic                    gnt_vld,
  output logic [$clog2(NQ)-1:0]   gnt_queue,
  output logic [$clog2(NCH)-1:0]  gnt_chan,
  output logic [IW-1:0]           gnt_idx,
  output logic [NQ-1:0]           rd_adv,
  output logic [NQ-1:0]           irq
);
  localparam int unsigned QW = $clog2(NQ);
  localparam int unsigned CW = $clog2(NCH);

  logic [NQ-1:0]          q_act, q_wsl, q_ack, q_empty, irqm;
  logic [NQ-1:0][CW-1:0]  q_ch;
  logic [NQ-1:0][IW-1:0]  q_rd;
  logic [NCH-1:0]         chen_w;
  logic                   hit, adv_en;
  logic [QW-1:0]          sel_q;
  logic [CW-1:0]          sel_ch;
  logic [NQ-1:0]          adv_vec;

  assign adv_en  = take && hit;
  assign adv_vec = adv_en ? (NQ'(1) << sel_q) : '0;

  qsched_regs #(.NQ(NQ), .NCH(NCH), .IW(IW)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .adv_en(adv_en), .adv_q(sel_q),
    .q_act(q_act), .q_wsl(q_wsl), .q_ack(q_ack), .q_empty(q_empty), .q_ch(q_ch),
    .q_rd(q_rd), .chen(chen_w), .irqm(irqm)
  );

  qsched_pick #(.NQ(NQ), .NCH(NCH)) u_pick (
    .clk(clk), .rst(rst), .take(take),
    .q_act(q_act), .q_wsl(q_wsl), .q_ack(q_ack), .q_empty(q_empty), .q_ch(q_ch),
    .chen(chen_w), .hit(hit), .sel_q(sel_q), .sel_ch(sel_ch)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_vld   <= 1'b0;
      gnt_queue <= '0;
      gnt_chan  <= '0;
      gnt_idx   <= '0;
      rd_adv    <= '0;
      irq       <= '0;
    end else begin
      gnt_vld <= adv_en;
      rd_adv  <= adv_vec;
      irq     <= adv_vec & irqm;
      if (adv_en) begin
        gnt_queue <= sel_q;
        gnt_chan  <= sel_ch;
        gnt_idx   <= q_rd[sel_q];
      end
    end
  end
endmodule

// File: rtl/qsched_chk.sv
module qsched_chk #(
  parameter int unsigned NQ  = 16,
  parameter int unsigned NCH = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   take,
  input logic                   gnt_vld,
  input logic [$clog2(NQ)-1:0]  gnt_queue,
  input logic [$clog2(NCH)-1:0] gnt_chan,
  input logic [NQ-1:0]          rd_adv,
  input logic [NQ-1:0]          irq,
  input logic [NCH-1:0]         chen
);
  logic [NCH-1:0] chen_q;
  always_ff @(posedge clk) chen_q <= rst ? '0 : chen;

  p_adv_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_adv));
  p_adv_is_granted_r6: assert property (@(posedge clk) disable iff (rst)
    gnt_vld |-> rd_adv[gnt_queue]);
  p_no_adv_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !gnt_vld |-> (rd_adv == '0));
  p_grant_after_take_r6: assert property (@(posedge clk) disable iff (rst)
    gnt_vld |-> $past(take));
  p_irq_within_adv_r10: assert property (@(posedge clk) disable iff (rst)
    (irq & ~rd_adv) == '0);
  p_chan_enabled_r9: assert property (@(posedge clk) disable iff (rst)
    gnt_vld |-> chen_q[gnt_chan]);
endmodule

bind qsched_top qsched_chk #(.NQ(NQ), .NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .take(take), .gnt_vld(gnt_vld), .gnt_queue(gnt_queue),
  .gnt_chan(gnt_chan), .rd_adv(rd_adv), .irq(irq), .chen(chen_w)
);

// File: tb/test_qsched_top.sv
`timescale 1ns/1ps
module test_qsched_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_addr = '0;
  logic [31:0] cfg_data = '0;
  logic        take = 1'b0;
  logic        gnt_vld;
  logic [3:0]  gnt_queue;
  logic [2:0]  gnt_chan;
  logic [7:0]  gnt_idx;
  logic [15:0] rd_adv, irq;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  qsched_top i_qsched_top (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .take(take), .gnt_vld(gnt_vld), .gnt_queue(gnt_queue), .gnt_chan(gnt_chan),
    .gnt_idx(gnt_idx), .rd_adv(rd_adv), .irq(irq)
  );

  // Reference model state
  int m_rd[16], m_wr[16], m_ch[16], m_last[8];
  bit m_act[16], m_wsl[16], m_ack[16], m_emp[16], m_irqm[16], m_chen[8];
  int grants_seen = 0;

  task automatic chk(string tag, string what, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit m_elig(int q);
    return m_act[q] && !m_emp[q] && m_chen[m_ch[q]] && (!m_ack[q] || m_wsl[q]);
  endfunction

  task automatic m_reset();
    for (int q = 0; q < 16; q++) begin
      m_rd[q] = 0; m_wr[q] = 0; m_ch[q] = 0; m_act[q] = 0; m_wsl[q] = 0;
      m_ack[q] = 0; m_emp[q] = 1; m_irqm[q] = 0;
    end
    for (int c = 0; c < 8; c++) begin m_chen[c] = 0; m_last[c] = 15; end
  endtask

  task automatic step(string tag, bit tk, bit we, logic [5:0] a, logic [31:0] d);
    bit e_vld = 0;
    int e_q = 0, e_c = 0, e_idx = 0;
    logic [15:0] e_adv = '0, e_irq = '0;
    @(negedge clk);
    take = tk; cfg_we = we; cfg_addr = a; cfg_data = d;
    if (tk) begin
      int best_c = -1;
      for (int c = 7; c >= 0 && best_c < 0; c--)
        for (int q = 0; q < 16; q++)
          if (m_elig(q) && m_ch[q] == c) best_c = c;
      if (best_c >= 0) begin
        for (int k = 16; k >= 1; k--) begin
          int q = (m_last[best_c] + k) % 16;
          if (m_elig(q) && m_ch[q] == best_c) e_q = q;
        end
        e_vld = 1; e_c = best_c; e_idx = m_rd[e_q];
        m_rd[e_q] = (m_rd[e_q] + 1) % 256;
        m_emp[e_q] = (m_rd[e_q] == m_wr[e_q]);
        m_last[best_c] = e_q;
        e_adv[e_q] = 1'b1;
        e_irq[e_q] = m_irqm[e_q];
      end
    end
    if (we) begin
      int i = a[3:0];
      case (a[5:4])
        2'd0: begin
          if (d[10]) m_act[i] = d[0];
          for (int b = 0; b < 3; b++)
            if (d[11+b]) m_ch[i] = (m_ch[i] & ~(1 << b)) | (int'(d[1+b]) << b);
          if (d[15]) m_wsl[i] = d[5];
          if (d[18]) m_ack[i] = d[8];
        end
        2'd1: begin m_wr[i] = d[7:0]; m_emp[i] = (m_rd[i] == m_wr[i]); end
        2'd2: begin m_rd[i] = d[7:0]; m_emp[i] = (m_rd[i] == m_wr[i]); end
        default: begin
          if (i == 0) for (int q = 0; q < 16; q++) if (d[16+q]) m_emp[q] = d[q];
          if (i == 1) for (int c = 0; c < 8; c++) m_chen[c] = d[c];
          if (i == 2) for (int q = 0; q < 16; q++) m_irqm[q] = d[q];
        end
      endcase
    end
    @(posedge clk); #1;
    if (gnt_vld) grants_seen++;
    chk(tag, "gnt_vld", gnt_vld, e_vld);
    if (e_vld && gnt_vld) begin
      chk(tag, "gnt_queue", gnt_queue, e_q);
      chk(tag, "gnt_chan", gnt_chan, e_c);
      chk(tag, "gnt_idx", gnt_idx, e_idx);
    end
    chk(tag, "rd_adv", rd_adv, e_adv);
    chk(tag, "irq", irq, e_irq);
    take = 0; cfg_we = 0;
  endtask

  task automatic wr(string tag, logic [5:0] a, logic [31:0] d);
    step(tag, 0, 1, a, d);
  endtask

  task automatic takes(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 1, 0, '0, '0);
  endtask

  // Full status write: all enables set
  function automatic logic [31:0] stat(bit act, int ch, bit wsl, bit ack);
    return 32'h0007_FC00 | 32'(act) | (32'(ch) << 1) | (32'(wsl) << 5) | (32'(ack) << 8);
  endfunction

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1", "gnt_vld after reset", gnt_vld, 0);
    chk("R1", "rd_adv after reset", rd_adv, 0);
    chk("R1", "irq after reset", irq, 0);
    takes("R1", 1);
    wr("R1", 6'h31, 32'hFF);
    wr("R1", 6'h00, stat(1, 1, 0, 0));
    takes("R1", 2);                        // active but never filled: no grant
    // R6 R7: single queue drains exactly
    wr("R7", 6'h10, 32'd3);
    takes("R6", 3);
    takes("R7", 2);
    // R4: channel priority across queues on channels 1, 2, 5
    wr("R4", 6'h10, 32'd5);
    wr("R4", 6'h01, stat(1, 2, 0, 0));
    wr("R4", 6'h11, 32'd2);
    wr("R4", 6'h02, stat(1, 5, 0, 0));
    wr("R4", 6'h12, 32'd2);
    takes("R4", 8);
    // R5: three queues sharing channel 3
    for (int q = 3; q <= 5; q++) begin
      wr("R5", 6'(q), stat(1, 3, 0, 0));
      wr("R5", 6'(16 + q), 32'd2);
    end
    takes("R5", 4);
    // R9: disabling channel 3 stops the rest
    wr("R9", 6'h31, 32'hF7);
    takes("R9", 2);
    wr("R9", 6'h31, 32'hFF);
    takes("R9", 3);
    // R2: partial status writes on queue 6
    wr("R2", 6'h06, stat(1, 4, 0, 0));
    wr("R2", 6'h16, 32'd4);
    wr("R2", 6'h06, 32'h0000_3800);        // channel bits only -> channel 0, still active
    takes("R2", 1);
    wr("R2", 6'h06, 32'h0000_0000 | 32'h0000_8020); // only window-left touched
    takes("R2", 1);
    wr("R2", 6'h06, 32'h0000_0001);        // no enables: active bit not cleared
    takes("R2", 1);
    wr("R2", 6'h06, 32'h0000_0400);        // enable only: deactivate
    takes("R2", 2);
    // R3: acknowledged-window mode needs window-space-left
    wr("R3", 6'h07, stat(1, 6, 0, 1));
    wr("R3", 6'h17, 32'd2);
    takes("R3", 1);
    wr("R3", 6'h07, 32'h0000_8020);
    takes("R3", 2);
    // R8: empty register masked writes on queue 8
    wr("R8", 6'h08, stat(1, 7, 0, 0));
    wr("R8", 6'h18, 32'd3);
    wr("R8", 6'h30, 32'h0100_0100);        // force empty
    takes("R8", 1);
    wr("R8", 6'h30, 32'h0000_0000);        // no enable: stays empty
    takes("R8", 1);
    wr("R8", 6'h30, 32'h0100_0000);        // clear flag
    takes("R8", 4);
    // R10: interrupt mask
    wr("R10", 6'h32, 32'h0000_0200);
    wr("R10", 6'h09, stat(1, 2, 0, 0));
    wr("R10", 6'h19, 32'd2);
    wr("R10", 6'h0A, stat(1, 2, 0, 0));
    wr("R10", 6'h1A, 32'd1);
    takes("R10", 4);
    // R11: index wrap
    wr("R11", 6'h2B, 32'd254);
    wr("R11", 6'h1B, 32'd1);
    wr("R11", 6'h0B, stat(1, 5, 0, 0));
    takes("R11", 4);
    chk("R6", "grants observed", grants_seen > 20, 1);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule